// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block turns the memory-controller configuration bytes that govern the legacy area below 1 MB into per-region steering controls. Thirteen shadow regions each get a read-enable and a write-enable. Region 0 is the system firmware area, and regions 1 through 12 are equal-sized expansion areas at consecutive addresses. A further output opens the 128 KB system-management RAM window at 0xA0000 to 0xBFFFF. The memory-steering logic that follows uses an asserted enable to send an access to DRAM, and otherwise forwards it to the PCI bus.

Configuration arrives one byte per cycle through a simple write port. Seven consecutive attribute bytes start at offset 0x59. Each byte carries two 4-bit fields, except the first byte, which carries only region 0 in its upper half. A separate control byte at offset 0x72 governs the management window. The window opens in one of two cases: the processor is in system-management mode and the gated enable bit is set, or the unconditional open bit is set. Writes to any other offset leave every output untouched.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, every region read-enable and write-enable is 0 and the management window is closed, whatever the level of `smm_active`.
- R2: Region 0 takes its controls from the upper nibble of the byte at offset 0x59. A write to 0x59 changes no other region, and the lower nibble of 0x59 has no effect on any output.
- R3: Region i, for i from 1 to 12, takes its controls from the byte at offset 0x59 + (i+1)/2. An odd i uses bits [3:0] of that byte and an even i uses bits [7:4].
- R4: Within a region's nibble, bit 0 is the read-enable and bit 1 is the write-enable. Nibble bits 2 and 3 have no effect.
- R5: A write to any offset outside 0x59..0x5F other than 0x72 changes no region output and leaves the management window in its previous state.
- R6: The window output equals (`smm_active` AND bit 3 of the 0x72 byte) OR bit 6 of the 0x72 byte. The other bits of that byte have no effect.
- R7: A configuration write becomes visible on the outputs just after the rising edge that samples it. A change on `smm_active` reaches the window output one rising edge after it is sampled, and not before that edge.
- R8: With `cfg_we` low, the outputs hold, whatever appears on `cfg_addr` and `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| smm_active | input | 1 | Processor is in system-management mode |
| region_rd_en | output | 13 | Per-region read steering to DRAM, bit i = region i |
| region_wr_en | output | 13 | Per-region write steering to DRAM, bit i = region i |
| smram_win_en | output | 1 | Management RAM window open |

## Verification
The hardest situation to reach is proving that a write cannot spill from one byte into a neighbour's region, or into the unused lower half of the first byte. The stimulus first gives every attribute byte a distinct background value. It then sweeps all 256 data values through each attribute byte in turn and compares all 26 region controls after every write, so any cross-talk between bytes or nibbles shows up as a mismatch. Every offset outside the decoded set is written with data that would change something if it were decoded. The window term is covered by driving all 256 control values under both levels of `smm_active`, and the mode-change latency is checked on both sides of the sampling edge.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

    // Nibble bit positions of the per-region control field
    localparam int NIB_RD = 0;
    localparam int NIB_WR = 1;

    typedef struct packed {
        logic wr;
        logic rd;
    } region_ctl_t;

    // Byte (relative to the attribute base) holding a region's field
    function automatic int byte_offset(input int region);
        return (region + 1) / 2;
    endfunction

    // Odd regions sit in the low nibble, even regions in the high nibble
    function automatic int nibble_shift(input int region);
        return (region % 2 == 1) ? 0 : 4;
    endfunction

endpackage

// File: rtl/shadow_region_field.sv
module shadow_region_field
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ATTR_BASE = 'h59,
    parameter int REGION    = 0
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  region_ctl_t       cur,
    output region_ctl_t       nxt
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ATTR_BASE + byte_offset(REGION));
    localparam int SHIFT = nibble_shift(REGION);

    logic hit;

    always_comb begin
        hit = we && (addr == MY_ADDR);
        nxt = cur;
        if (hit) begin
            nxt.rd = wdata[SHIFT + NIB_RD];
            nxt.wr = wdata[SHIFT + NIB_WR];
        end
    end
endmodule

// File: rtl/shadow_smram_ctl.sv
module shadow_smram_ctl #(
    parameter int ADDR_W     = 8,
    parameter int SMRAM_ADDR = 'h72,
    parameter int EN_BIT     = 3,
    parameter int OPEN_BIT   = 6
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              cur_gate,
    input  logic              cur_open,
    output logic              nxt_gate,
    output logic              nxt_open
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SMRAM_ADDR);

    always_comb begin
        nxt_gate = cur_gate;
        nxt_open = cur_open;
        if (we && (addr == MY_ADDR)) begin
            nxt_gate = wdata[EN_BIT];
            nxt_open = wdata[OPEN_BIT];
        end
    end
endmodule

// File: rtl/shadow_smram_gate.sv
module shadow_smram_gate (
    input  logic gate_bit,
    input  logic open_bit,
    input  logic smm,
    output logic win
);
    always_comb begin
        win = (smm && gate_bit) || open_bit;
    end
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
    import shadow_attr_pkg::*;
#(
    parameter int          ADDR_W         = 8,
    parameter int          NUM_REGIONS    = 13,
    parameter int          ATTR_BASE      = 'h59,
    parameter int          SMRAM_ADDR     = 'h72,
    parameter logic [7:0]  SMRAM_RESET    = 8'h02,
    parameter int          SMRAM_EN_BIT   = 3,
    parameter int          SMRAM_OPEN_BIT = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [7:0]             cfg_wdata,
    input  logic                   smm_active,
    output logic [NUM_REGIONS-1:0] region_rd_en,
    output logic [NUM_REGIONS-1:0] region_wr_en,
    output logic                   smram_win_en
);
    typedef struct packed {
        region_ctl_t [NUM_REGIONS-1:0] rgn;
        logic                          sm_gate;
        logic                          sm_open;
        logic                          win;
    } state_t;

    localparam logic RST_GATE = SMRAM_RESET[SMRAM_EN_BIT];
    localparam logic RST_OPEN = SMRAM_RESET[SMRAM_OPEN_BIT];

    state_t st_d, st_q;

    region_ctl_t [NUM_REGIONS-1:0] rgn_nxt;
    logic                          gate_nxt, open_nxt, win_nxt;
    logic                          smram_gate_q, smram_open_q;
    logic                          unused_wdata;

    // Per-region field capture
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
        shadow_region_field #(
            .ADDR_W    (ADDR_W),
            .ATTR_BASE (ATTR_BASE),
            .REGION    (i)
        ) u_fld (
            .we    (cfg_we),
            .addr  (cfg_addr),
            .wdata (cfg_wdata),
            .cur   (st_q.rgn[i]),
            .nxt   (rgn_nxt[i])
        );
    end

    shadow_smram_ctl #(
        .ADDR_W     (ADDR_W),
        .SMRAM_ADDR (SMRAM_ADDR),
        .EN_BIT     (SMRAM_EN_BIT),
        .OPEN_BIT   (SMRAM_OPEN_BIT)
    ) u_smctl (
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cur_gate (st_q.sm_gate),
        .cur_open (st_q.sm_open),
        .nxt_gate (gate_nxt),
        .nxt_open (open_nxt)
    );

    // Window evaluated from the next control bits, so a write shows at once
    shadow_smram_gate u_gate (
        .gate_bit (gate_nxt),
        .open_bit (open_nxt),
        .smm      (smm_active),
        .win      (win_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rgn     = rgn_nxt;
        st_d.sm_gate = gate_nxt;
        st_d.sm_open = open_nxt;
        st_d.win     = win_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.sm_gate <= RST_GATE;
            st_q.sm_open <= RST_OPEN;
            st_q.win     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_REGIONS; i++) begin
            region_rd_en[i] = st_q.rgn[i].rd;
            region_wr_en[i] = st_q.rgn[i].wr;
        end
        smram_win_en = st_q.win;
        smram_gate_q = st_q.sm_gate;
        smram_open_q = st_q.sm_open;
        unused_wdata = ^cfg_wdata;
    end
endmodule

// File: rtl/shadow_attr_checker.sv
module shadow_attr_checker
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int NUM_REGIONS    = 13,
    parameter int ATTR_BASE      = 'h59,
    parameter int SMRAM_ADDR     = 'h72,
    parameter int SMRAM_EN_BIT   = 3,
    parameter int SMRAM_OPEN_BIT = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [ADDR_W-1:0]      cfg_addr,
    input logic [7:0]             cfg_wdata,
    input logic                   smm_active,
    input logic [NUM_REGIONS-1:0] region_rd_en,
    input logic [NUM_REGIONS-1:0] region_wr_en,
    input logic                   smram_win_en,
    input logic                   smram_gate_q,
    input logic                   smram_open_q
);
    localparam int ATTR_BYTES = byte_offset(NUM_REGIONS - 1) + 1;
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ATTR_BASE);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ATTR_BASE + ATTR_BYTES - 1);
    localparam logic [ADDR_W-1:0] S_AD = ADDR_W'(SMRAM_ADDR);

    logic decoded;
    assign decoded = ((cfg_addr >= A_LO) && (cfg_addr <= A_HI)) || (cfg_addr == S_AD);

    // R8: no write strobe, no change
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(region_rd_en) && $stable(region_wr_en));

    // R5: undecoded offsets have no effect on the regions
    p_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !decoded) |=> $stable(region_rd_en) && $stable(region_wr_en));

    // R2: the first attribute byte drives region 0 from its upper nibble only
    p_region0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_LO) |=>
            (region_rd_en[0] == $past(cfg_wdata[4 + NIB_RD])) &&
            (region_wr_en[0] == $past(cfg_wdata[4 + NIB_WR])) &&
            $stable(region_rd_en[NUM_REGIONS-1:1]) &&
            $stable(region_wr_en[NUM_REGIONS-1:1]));

    // R6 / R7: window follows stored control bits and the sampled mode
    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> smram_win_en == (($past(smm_active) && smram_gate_q) || smram_open_q));
endmodule

bind shadow_attr_decoder shadow_attr_checker #(
    .ADDR_W         (ADDR_W),
    .NUM_REGIONS    (NUM_REGIONS),
    .ATTR_BASE      (ATTR_BASE),
    .SMRAM_ADDR     (SMRAM_ADDR),
    .SMRAM_EN_BIT   (SMRAM_EN_BIT),
    .SMRAM_OPEN_BIT (SMRAM_OPEN_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .smm_active   (smm_active),
    .region_rd_en (region_rd_en),
    .region_wr_en (region_wr_en),
    .smram_win_en (smram_win_en),
    .smram_gate_q (smram_gate_q),
    .smram_open_q (smram_open_q)
);

// File: tb/sim_shadow_attr_decoder.sv
`timescale 1ns/1ps
module sim_shadow_attr_decoder;
    localparam int NR    = 13;
    localparam int NB    = 7;
    localparam int BASE  = 'h59;
    localparam int SMADR = 'h72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          smm_active = 1'b0;
    logic [NR-1:0] region_rd_en, region_wr_en;
    logic          smram_win_en;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic [7:0] attr_m [NB];
    logic [7:0] sm_m;

    always #2 clk = ~clk;

    shadow_attr_decoder u0 (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .smm_active,
        .region_rd_en, .region_wr_en, .smram_win_en
    );

    function automatic logic [NR-1:0] exp_rd();
        logic [NR-1:0] v;
        for (int i = 0; i < NR; i++)
            v[i] = attr_m[(i + 1) / 2][((i % 2) == 1 ? 0 : 4) + 0];
        return v;
    endfunction

    function automatic logic [NR-1:0] exp_wr();
        logic [NR-1:0] v;
        for (int i = 0; i < NR; i++)
            v[i] = attr_m[(i + 1) / 2][((i % 2) == 1 ? 0 : 4) + 1];
        return v;
    endfunction

    function automatic logic exp_win();
        return (smm_active && sm_m[3]) || sm_m[6];
    endfunction

    task automatic check_all(input string req);
        n_vec++;
        if (region_rd_en !== exp_rd() || region_wr_en !== exp_wr() || smram_win_en !== exp_win()) begin
            n_bad++;
            $display("FAIL %s: rd=%h wr=%h win=%b expected rd=%h wr=%h win=%b", req,
                     region_rd_en, region_wr_en, smram_win_en, exp_rd(), exp_wr(), exp_win());
        end
    endtask

    task automatic check_win(input string req, input logic exp);
        n_vec++;
        if (smram_win_en !== exp) begin
            n_bad++;
            $display("FAIL %s: win=%b expected %b", req, smram_win_en, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'(BASE) && a < 8'(BASE + NB)) attr_m[a - 8'(BASE)] = d;
        if (a == 8'(SMADR)) sm_m = d;
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) attr_m[b] = 8'h00;
        sm_m = 8'h02;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        smm_active = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 reset state with smm high");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");
        smm_active = 1'b0;
        @(negedge clk);

        // Distinct background per byte
        for (int b = 0; b < NB; b++) begin
            wr(8'(BASE + b), 8'(8'h13 * (b + 1)));
            check_all("R3 background fill");
        end

        // R2 R3 R4: full data sweep of every attribute byte
        for (int b = 0; b < NB; b++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8'(BASE + b), 8'(v));
                check_all(b == 0 ? "R2 R4 first byte sweep" : "R3 R4 byte sweep");
            end
        end

        // Restore a mixed pattern
        for (int b = 0; b < NB; b++) wr(8'(BASE + b), 8'(8'h5A ^ (b * 8'h21)));
        check_all("R3 mixed pattern");

        // R5: every undecoded offset
        for (int a = 0; a < 256; a++) begin
            if ((a >= BASE && a < BASE + NB) || a == SMADR) continue;
            @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 8'(~a) | 8'h4B;
            @(negedge clk);
            cfg_we = 1'b0;
            check_all("R5 undecoded offset");
        end

        // R8: strobe low with decoded offsets on the bus
        @(negedge clk);
        cfg_addr = 8'(BASE); cfg_wdata = 8'hFF;
        repeat (2) @(negedge clk);
        cfg_addr = 8'(BASE + 3); cfg_wdata = 8'h00;
        repeat (2) @(negedge clk);
        cfg_addr = 8'(SMADR); cfg_wdata = 8'h40;
        repeat (2) @(negedge clk);
        check_all("R8 strobe low holds");

        // R6: window term over all control values and both mode levels
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            smm_active = s[0];
            for (int v = 0; v < 256; v++) begin
                wr(8'(SMADR), 8'(v));
                check_all("R6 window term");
            end
        end

        // R7: write latency and mode-change latency
        @(negedge clk);
        smm_active = 1'b0;
        wr(8'(SMADR), 8'h08);
        check_win("R7 gated, smm low", 1'b0);
        @(negedge clk);
        smm_active = 1'b1;
        #1;
        check_win("R7 before sampling edge", 1'b0);
        @(negedge clk);
        check_win("R7 after sampling edge", 1'b1);
        smm_active = 1'b0;
        @(negedge clk);
        check_win("R7 mode drop", 1'b0);

        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(BASE + 6); cfg_wdata = 8'h21;
        #1;
        n_vec++;
        if (region_rd_en[12] !== attr_m[6][4]) begin
            n_bad++;
            $display("FAIL R7: early update rd12=%b expected %b", region_rd_en[12], attr_m[6][4]);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        attr_m[6] = 8'h21;
        check_all("R7 visible after edge");

        // R1: reset mid-run clears everything
        smm_active = 1'b1;
        wr(8'(SMADR), 8'h48);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check_all("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 post reset hold");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule